// File: doc/BRIEF.md
# Flash Command Status Lockout Unit

This block sits between a host that issues flash command bytes and the engine that carries out erase and program operations on the cell array. It keeps an 8-bit status word. It turns the outcome of finished operations into one of four error classes. While an earlier error has not been cleared, it refuses every command that would modify the array. Each command byte it receives is either accepted or rejected. Accepted modifying commands are passed to the engine as a one-cycle launch pulse with an operation kind.

The status word holds a ready flag in bit 7 and three error bits. Bit 5 is the erase error, bit 4 the program error and bit 3 the block-program error. Bits 6 and 2..0 always read 0. A host reads the status at any time through the status port. It can also send the status-read byte, which stays legal even while the engine is busy. A clear byte wipes the error bits and lifts the lockout. Some commands take two bytes: a setup byte, then a confirm byte. A wrong confirm byte is recorded as a sequence error.

Top module: `fcmd_guard`

## Requirements
- R1: After reset, `status` reads 0x80, `err_class` reads 0, and `cmd_accept`, `cmd_reject` and `launch` are all low.
- R2: `err_class` decodes the status as follows, checking in this priority order. Bits 5 and 4 both set gives 1 (sequence). Only bit 5 set gives 2 (erase). Only bit 4 set gives 3 (page or lock-bit program). Bit 3 set with bits 5 and 4 clear gives 4 (block program). Anything else gives 0.
- R3: While ready, byte 0x50 is accepted and clears status bits 5..3 on the next edge.
- R4: While ready and unlocked, byte 0x41 (page program) is accepted and launches kind 0. Ready drops in the same cycle that `launch` is high.
- R5: While ready and unlocked, a setup byte is accepted and arms a pending confirm. The setup bytes are 0x20 (block erase, kind 2), 0xA7 (erase all unlocked blocks, kind 2), 0x77 (lock-bit program, kind 1) and 0xE8 (block program, kind 3). A following 0xD0 is accepted and launches that kind.
- R6: If the byte after a setup byte is anything other than 0xD0, status bits 5 and 4 are set. That byte gives no launch, no accept pulse and no reject pulse, and the pending confirm is dropped.
- R7: While any of status bits 5..3 is set, bytes 0x41, 0x20, 0xA7, 0x77 and 0xE8 are rejected and the status does not change.
- R8: While busy (bit 7 = 0), every byte except 0x70 is rejected without changing the status. Byte 0x70 is accepted.
- R9: `op_done` while busy sets bit 7. If `op_fail` is also high, the kind selects the error bit: kinds 0 and 1 set bit 4, kind 2 sets bit 5, kind 3 sets bit 3.
- R10: `op_done` while ready is ignored, and the status stays unchanged.
- R11: While ready, 0x70 (read status) and 0x71 (read lock status) are accepted even when locked. Any byte with no command meaning is rejected. `cmd_accept` and `cmd_reject` are never high together.
- R12: When a command byte and `op_done` arrive in the same cycle, the byte is judged as arriving while busy, and the completion updates the status on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| op_done | input | 1 | Engine completion pulse |
| op_fail | input | 1 | Completion carries a failure |
| op_kind | input | 2 | Kind of the completing operation |
| launch | output | 1 | One-cycle start pulse to the engine |
| launch_kind | output | 2 | Kind of the launched operation |
| cmd_accept | output | 1 | Command byte accepted (one cycle) |
| cmd_reject | output | 1 | Command byte rejected (one cycle) |
| status | output | 8 | Status register |
| err_class | output | 3 | Decoded error class |

## Verification
Two events can land on the same edge: a command byte arriving and an engine completion. The bench provokes this in two ways. First it sends a clear byte in the cycle a passing operation finishes; the clear must be rejected, and ready must still rise. Then it sends a status-read byte while a failing page program finishes; the byte must be accepted, and bit 4 must appear together with ready. A reference model in the scoreboard predicts both outcomes, and it assumes the command was judged against the busy state from before that edge.

// File: rtl/fcmd_pkg.sv
// Shared codes and types for the flash command status lockout unit.
// Assumes 8-bit command bytes and an 8-bit status word.
package fcmd_pkg;
    localparam int CMD_W  = 8;
    localparam int STAT_W = 8;
    localparam int KIND_W = 2;

    // Status bit positions (decoded by the error classifier)
    localparam int BIT_RDY = 7;
    localparam int BIT_ERS = 5;
    localparam int BIT_PGM = 4;
    localparam int BIT_BLK = 3;
    localparam logic [STAT_W-1:0] STAT_RESET = 8'h80;

    localparam logic [CMD_W-1:0] OP_RD_STAT   = 8'h70;
    localparam logic [CMD_W-1:0] OP_RD_LOCK   = 8'h71;
    localparam logic [CMD_W-1:0] OP_CLEAR     = 8'h50;
    localparam logic [CMD_W-1:0] OP_PAGE      = 8'h41;
    localparam logic [CMD_W-1:0] OP_ERASE     = 8'h20;
    localparam logic [CMD_W-1:0] OP_ERASE_ALL = 8'hA7;
    localparam logic [CMD_W-1:0] OP_LOCKBIT   = 8'h77;
    localparam logic [CMD_W-1:0] OP_BLKPGM    = 8'hE8;
    localparam logic [CMD_W-1:0] OP_CONFIRM   = 8'hD0;

    localparam logic [KIND_W-1:0] K_PAGE  = 2'd0;
    localparam logic [KIND_W-1:0] K_LOCK  = 2'd1;
    localparam logic [KIND_W-1:0] K_ERASE = 2'd2;
    localparam logic [KIND_W-1:0] K_BLOCK = 2'd3;

    typedef enum logic [2:0] {
        C_NONE  = 3'd0,
        C_SEQ   = 3'd1,
        C_ERASE = 3'd2,
        C_PAGE  = 3'd3,
        C_BLOCK = 3'd4
    } err_class_e;

    typedef enum logic [2:0] {
        B_OTHER,
        B_READ,
        B_CLEAR,
        B_PAGE,
        B_SETUP
    } byte_cls_e;
endpackage

// File: rtl/fcmd_decode.sv
// Byte classifier: sorts a command byte into a class and, for setup
// bytes, the operation kind they arm. Purely combinational.
module fcmd_decode
    import fcmd_pkg::*;
(
    input  logic [CMD_W-1:0]  byte_in,
    output byte_cls_e         cls,
    output logic [KIND_W-1:0] setup_kind,
    output logic              is_confirm,
    output logic              is_rdstat
);
    // Map each byte value to its class and armed kind
    always_comb begin
        cls        = B_OTHER;
        setup_kind = K_ERASE;
        case (byte_in)
            OP_RD_STAT, OP_RD_LOCK: cls = B_READ;
            OP_CLEAR:               cls = B_CLEAR;
            OP_PAGE:                cls = B_PAGE;
            OP_ERASE, OP_ERASE_ALL: begin cls = B_SETUP; setup_kind = K_ERASE; end
            OP_LOCKBIT:             begin cls = B_SETUP; setup_kind = K_LOCK;  end
            OP_BLKPGM:              begin cls = B_SETUP; setup_kind = K_BLOCK; end
            default:                cls = B_OTHER;
        endcase
    end

    assign is_confirm = (byte_in == OP_CONFIRM);
    assign is_rdstat  = (byte_in == OP_RD_STAT);
endmodule

// File: rtl/fcmd_seq.sv
// Command sequencer: decides accept, reject, launch, clear and sequence
// error for each byte, and tracks a pending two-byte confirm.
// Assumes the ready and lock inputs come from the status register.
module fcmd_seq
    import fcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  byte_cls_e         cls,
    input  logic [KIND_W-1:0] setup_kind,
    input  logic              is_confirm,
    input  logic              is_rdstat,
    input  logic              ready,
    input  logic              locked,
    output logic              acc_c,
    output logic              rej_c,
    output logic              launch_c,
    output logic              clr_c,
    output logic              seqerr_c,
    output logic              acc_q,
    output logic              rej_q,
    output logic              launch_q,
    output logic [KIND_W-1:0] kind_q
);
    logic              pend_q;
    logic [KIND_W-1:0] pend_kind_q;
    logic              pend_set, pend_clr;
    logic [KIND_W-1:0] kind_c;

    // Judge the current byte against pending, busy and lock state
    always_comb begin
        acc_c    = 1'b0;
        rej_c    = 1'b0;
        launch_c = 1'b0;
        clr_c    = 1'b0;
        seqerr_c = 1'b0;
        pend_set = 1'b0;
        pend_clr = 1'b0;
        kind_c   = pend_kind_q;
        if (cmd_valid) begin
            if (pend_q) begin
                pend_clr = 1'b1;
                if (is_confirm) begin
                    acc_c    = 1'b1;
                    launch_c = 1'b1;
                end else begin
                    seqerr_c = 1'b1;
                end
            end else if (!ready) begin
                if (is_rdstat) acc_c = 1'b1;
                else           rej_c = 1'b1;
            end else begin
                case (cls)
                    B_READ:  acc_c = 1'b1;
                    B_CLEAR: begin acc_c = 1'b1; clr_c = 1'b1; end
                    B_PAGE: begin
                        if (locked) rej_c = 1'b1;
                        else begin
                            acc_c    = 1'b1;
                            launch_c = 1'b1;
                            kind_c   = K_PAGE;
                        end
                    end
                    B_SETUP: begin
                        if (locked) rej_c = 1'b1;
                        else begin
                            acc_c    = 1'b1;
                            pend_set = 1'b1;
                        end
                    end
                    default: rej_c = 1'b1;
                endcase
            end
        end
    end

    // Hold the armed two-byte command until its confirm slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_kind_q <= K_PAGE;
        end else if (pend_set) begin
            pend_q      <= 1'b1;
            pend_kind_q <= setup_kind;
        end else if (pend_clr) begin
            pend_q      <= 1'b0;
        end
    end

    // Register the one-cycle result pulses toward host and engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= 1'b0;
            rej_q    <= 1'b0;
            launch_q <= 1'b0;
            kind_q   <= K_PAGE;
        end else begin
            acc_q    <= acc_c;
            rej_q    <= rej_c;
            launch_q <= launch_c;
            if (launch_c) kind_q <= kind_c;
        end
    end

    // R5
    pend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> ready);

    // R11
    acc_rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_q && rej_q));
endmodule

// File: rtl/fcmd_status.sv
// Status register: ready flag and three error bits, updated by launch,
// completion, clear and sequence-error events. Other bits read zero.
// Assumes clear and sequence error only occur while ready.
module fcmd_status
    import fcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_c,
    input  logic              clr_c,
    input  logic              seqerr_c,
    input  logic              op_done,
    input  logic              op_fail,
    input  logic [KIND_W-1:0] op_kind,
    output logic [STAT_W-1:0] stat
);
    // Apply all status events that fall on this edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= STAT_RESET;
        end else begin
            if (launch_c) stat[BIT_RDY] <= 1'b0;
            if (op_done && !stat[BIT_RDY]) begin
                stat[BIT_RDY] <= 1'b1;
                if (op_fail) begin
                    case (op_kind)
                        K_PAGE, K_LOCK: stat[BIT_PGM] <= 1'b1;
                        K_ERASE:        stat[BIT_ERS] <= 1'b1;
                        default:        stat[BIT_BLK] <= 1'b1;
                    endcase
                end
            end
            if (clr_c) begin
                stat[BIT_ERS] <= 1'b0;
                stat[BIT_PGM] <= 1'b0;
                stat[BIT_BLK] <= 1'b0;
            end
            if (seqerr_c) begin
                stat[BIT_ERS] <= 1'b1;
                stat[BIT_PGM] <= 1'b1;
            end
        end
    end

    // R3
    clear_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_c |=> (stat[BIT_ERS:BIT_BLK] == 3'b000));

    // R6
    seqerr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seqerr_c |=> (stat[BIT_ERS] && stat[BIT_PGM]));

    // R9
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !stat[BIT_RDY]) |=> stat[BIT_RDY]);

    // R10
    idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && stat[BIT_RDY] && !launch_c && !clr_c && !seqerr_c) |=> $stable(stat));
endmodule

// File: rtl/fcmd_errclass.sv
// Error classifier: turns status bits 5..3 into a class code, with the
// sequence case taking priority. Purely combinational.
module fcmd_errclass
    import fcmd_pkg::*;
(
    input  logic       ers,
    input  logic       pgm,
    input  logic       blk,
    output err_class_e cls
);
    // Priority decode of the three error bits
    always_comb begin
        if (ers && pgm)  cls = C_SEQ;
        else if (ers)    cls = C_ERASE;
        else if (pgm)    cls = C_PAGE;
        else if (blk)    cls = C_BLOCK;
        else             cls = C_NONE;
    end
endmodule

// File: rtl/fcmd_guard.sv
// Top of the flash command status lockout unit. Ties the byte classifier,
// the sequencer, the status register and the error classifier together.
// Assumes the engine raises op_done once per launch.
module fcmd_guard
    import fcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_byte,
    input  logic              op_done,
    input  logic              op_fail,
    input  logic [KIND_W-1:0] op_kind,
    output logic              launch,
    output logic [KIND_W-1:0] launch_kind,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic [STAT_W-1:0] status,
    output logic [2:0]        err_class
);
    byte_cls_e         bcls;
    logic [KIND_W-1:0] setup_kind;
    logic              is_confirm, is_rdstat;
    logic              acc_c, rej_c, launch_c, clr_c, seqerr_c;
    logic              ready, locked;
    err_class_e        ecls;

    assign ready  = status[BIT_RDY];
    assign locked = status[BIT_ERS] | status[BIT_PGM] | status[BIT_BLK];

    fcmd_decode u_decode (
        .byte_in    (cmd_byte),
        .cls        (bcls),
        .setup_kind (setup_kind),
        .is_confirm (is_confirm),
        .is_rdstat  (is_rdstat)
    );

    fcmd_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cls        (bcls),
        .setup_kind (setup_kind),
        .is_confirm (is_confirm),
        .is_rdstat  (is_rdstat),
        .ready      (ready),
        .locked     (locked),
        .acc_c      (acc_c),
        .rej_c      (rej_c),
        .launch_c   (launch_c),
        .clr_c      (clr_c),
        .seqerr_c   (seqerr_c),
        .acc_q      (cmd_accept),
        .rej_q      (cmd_reject),
        .launch_q   (launch),
        .kind_q     (launch_kind)
    );

    fcmd_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_c (launch_c),
        .clr_c    (clr_c),
        .seqerr_c (seqerr_c),
        .op_done  (op_done),
        .op_fail  (op_fail),
        .op_kind  (op_kind),
        .stat     (status)
    );

    fcmd_errclass u_errclass (
        .ers (status[BIT_ERS]),
        .pgm (status[BIT_PGM]),
        .blk (status[BIT_BLK]),
        .cls (ecls)
    );

    assign err_class = ecls;

    // R4
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !status[BIT_RDY]);

    // R7
    launch_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> ($past(status[BIT_ERS:BIT_BLK]) == 3'b000));

    // R8
    launch_from_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> $past(status[BIT_RDY]));

    // R7
    reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rej_c && !op_done) |=> $stable(status));

    // R2
    seq_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_ERS] && status[BIT_PGM]) |-> (err_class == 3'd1));
endmodule

// File: tb/fcmd_guard_tb_top.sv
// Scoreboard bench: the driver predicts each cycle's result from a model
// of the requirements and queues it; the monitor compares after the edge.
module fcmd_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [7:0] cmd_byte;
    logic       op_done, op_fail;
    logic [1:0] op_kind;
    logic       launch;
    logic [1:0] launch_kind;
    logic       cmd_accept, cmd_reject;
    logic [7:0] status;
    logic [2:0] err_class;

    always #10 clk = ~clk;

    fcmd_guard dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .op_done(op_done), .op_fail(op_fail), .op_kind(op_kind),
        .launch(launch), .launch_kind(launch_kind), .cmd_accept(cmd_accept),
        .cmd_reject(cmd_reject), .status(status), .err_class(err_class)
    );

    typedef struct {
        logic       acc;
        logic       rej;
        logic       lau;
        logic [1:0] kind;
        logic [7:0] st;
        logic [2:0] cls;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic       arm = 1'b0;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] m_stat;
    logic       m_pend;
    logic [1:0] m_pkind;

    function automatic logic [2:0] class_of(input logic [7:0] s);
        if (s[5] && s[4]) return 3'd1;
        if (s[5])         return 3'd2;
        if (s[4])         return 3'd3;
        if (s[3])         return 3'd4;
        return 3'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: predict, queue, then present one cycle of stimulus
    task automatic step(input bit cv, input logic [7:0] b, input bit dn,
                        input bit fl, input logic [1:0] k, input string tag);
        exp_t e;
        logic [7:0] ns;
        bit busy, lk;
        ns = m_stat;
        busy = !m_stat[7];
        lk = |m_stat[5:3];
        e.acc = 0; e.rej = 0; e.lau = 0; e.kind = 0;
        if (cv) begin
            if (m_pend) begin
                m_pend = 0;
                if (b == 8'hD0) begin e.acc = 1; e.lau = 1; e.kind = m_pkind; ns[7] = 0; end
                else begin ns[5] = 1; ns[4] = 1; end
            end else if (busy) begin
                if (b == 8'h70) e.acc = 1; else e.rej = 1;
            end else begin
                case (b)
                    8'h70, 8'h71: e.acc = 1;
                    8'h50: begin e.acc = 1; ns[5:3] = 3'b000; end
                    8'h41: if (lk) e.rej = 1;
                           else begin e.acc = 1; e.lau = 1; e.kind = 2'd0; ns[7] = 0; end
                    8'h20, 8'hA7, 8'h77, 8'hE8:
                           if (lk) e.rej = 1;
                           else begin
                               e.acc = 1; m_pend = 1;
                               m_pkind = (b == 8'h77) ? 2'd1 : (b == 8'hE8) ? 2'd3 : 2'd2;
                           end
                    default: e.rej = 1;
                endcase
            end
        end
        if (dn && busy) begin
            ns[7] = 1;
            if (fl) begin
                case (k)
                    2'd0, 2'd1: ns[4] = 1;
                    2'd2:       ns[5] = 1;
                    default:    ns[3] = 1;
                endcase
            end
        end
        m_stat = ns;
        e.st = ns;
        e.cls = class_of(ns);
        e.tag = tag;
        sb_q.push_back(e);
        cmd_valid = cv; cmd_byte = b; op_done = dn; op_fail = fl; op_kind = k;
        arm = 1'b1;
        @(negedge clk);
        cmd_valid = 0; cmd_byte = 8'h00; op_done = 0; op_fail = 0; op_kind = 2'd0;
        arm = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b, input string tag);
        step(1, b, 0, 0, 2'd0, tag);
    endtask

    task automatic done(input bit fl, input logic [1:0] k, input string tag);
        step(0, 8'h00, 1, fl, k, tag);
    endtask

    // Monitor: pop the expected item and compare after the edge settles
    always @(posedge clk) begin
        if (arm) begin
            exp_t e;
            #2;
            e = sb_q.pop_front();
            chk({e.tag, " accept"}, 32'(cmd_accept), 32'(e.acc));
            chk({e.tag, " reject"}, 32'(cmd_reject), 32'(e.rej));
            chk({e.tag, " launch"}, 32'(launch), 32'(e.lau));
            if (e.lau) chk({e.tag, " kind"}, 32'(launch_kind), 32'(e.kind));
            chk({e.tag, " status"}, 32'(status), 32'(e.st));
            chk({e.tag, " class"}, 32'(err_class), 32'(e.cls));
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; cmd_valid = 0; cmd_byte = 8'h00;
        op_done = 0; op_fail = 0; op_kind = 2'd0;
        m_stat = 8'h80; m_pend = 0; m_pkind = 2'd0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 status", 32'(status), 32'h80);
        chk("R1 class", 32'(err_class), 32'd0);
        chk("R1 pulses", 32'({cmd_accept, cmd_reject, launch}), 32'd0);
        rst_n = 1;
        @(negedge clk);

        cmd(8'h70, "R11 read status");
        cmd(8'h71, "R11 read lock");
        cmd(8'h33, "R11 unknown byte");

        cmd(8'h41, "R4 page program");
        cmd(8'h50, "R8 clear while busy");
        cmd(8'h70, "R8 status read while busy");
        cmd(8'h20, "R8 setup while busy");
        done(0, 2'd0, "R9 pass completion");

        done(1, 2'd2, "R10 done while ready");

        cmd(8'h20, "R5 erase setup");
        cmd(8'hD0, "R5 erase confirm");
        done(1, 2'd2, "R9 erase fail");

        cmd(8'h41, "R7 page locked");
        cmd(8'h20, "R7 erase locked");
        cmd(8'hA7, "R7 erase all locked");
        cmd(8'h77, "R7 lock bit locked");
        cmd(8'hE8, "R7 block program locked");
        cmd(8'h70, "R11 status read locked");
        cmd(8'h71, "R11 lock read locked");
        cmd(8'h50, "R3 clear");

        cmd(8'h77, "R5 lock bit setup");
        cmd(8'hD0, "R5 lock bit confirm");
        done(1, 2'd1, "R9 lock bit fail");
        cmd(8'h50, "R3 clear pgm");

        cmd(8'hE8, "R5 block setup");
        cmd(8'hD0, "R5 block confirm");
        done(1, 2'd3, "R9 block fail R2");
        cmd(8'h20, "R7 bit3 lockout");
        cmd(8'h50, "R3 clear blk");

        cmd(8'hA7, "R5 erase all setup");
        cmd(8'h41, "R6 bad confirm R2");
        cmd(8'h41, "R7 after sequence error");
        cmd(8'h50, "R3 clear seq");

        cmd(8'h41, "R4 page program again");
        step(1, 8'h50, 1, 0, 2'd0, "R12 clear with completion");
        cmd(8'h41, "R4 page program third");
        step(1, 8'h70, 1, 1, 2'd0, "R12 read with failing completion");
        cmd(8'h50, "R3 final clear");

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule